// File: doc/BRIEF.md
# ECC Error Location Bit Corrector

This block applies the result of a BCH decoder to one sector held in a local buffer. The buffer holds 512 data bytes followed by an 8-byte free-data area. It is reached through a byte-wide RAM port whose read data arrives one cycle after the read request. A request names a sector slot from 0 to 7. The block waits until the decoder raises that slot's done bit. It then captures the slot's 4-bit error count from a packed count word, along with a bank of error-location words. Each location is a 13-bit bit address, and two locations are packed into each 32-bit word.

Locations are handled one at a time, lowest index first. A location that falls in the data area or in the free-data area becomes a read-modify-write of one byte, inverting one bit. A location that falls in the parity area touches no memory but is still counted. When the last write-back is done, the block presents the number of reported errors, or an uncorrectable flag.

Requests use a valid/ready handshake, and `req_ready` is high only while the block is idle. Results use a valid/ready handshake too. Once `res_valid` rises it stays high with stable `res_count` and `res_uncorr` until `res_ready` is seen, so a slow consumer stalls the block before it accepts its next request. The done bits and the count and location inputs are plain level signals. They must stay steady from the request until the result is taken.

Top module: `ecc_bitfix_top`

## Requirements
- R1: The count for slot n is bits [4n+3:4n] of `err_cnt_word`; the fields of other slots have no effect on the result or the buffer.
- R2: A count of 0 produces a result with `res_count` 0 and `res_uncorr` 0, with no buffer access.
- R3: A count of 15 produces `res_uncorr` 1 and `res_count` 0, with no buffer access and no bit changed.
- R4: Location i is taken from word i/2 of `err_loc_bank` (bits [32k+31:32k] are word k): bits 12:0 for even i, bits 28:16 for odd i; bits 15:13 and 31:29 are ignored.
- R5: A location L below 4096 inverts bit L&7 of buffer byte L>>3.
- R6: A location L from 4096 to 4159 inverts bit L&7 of free-data byte (L>>3)-512, which sits at buffer address L>>3 (512 to 519).
- R7: A location of 4160 or more causes no buffer access; no buffer address of 520 or more is ever driven with an enable.
- R8: For counts 1 to 14, `res_count` equals the count, including locations that fall in parity.
- R9: After a request is accepted, no buffer access happens until `sector_done[slot]` is high.
- R10: Each flip is a read followed in the next cycle by a write to the same address, in increasing index order; two reports of one bit cancel out.
- R11: `req_ready` is high only when idle; `res_valid` holds, with stable count and flag, until `res_ready`, then drops the next cycle.
- R12: After reset `req_ready` is 1, `res_valid` is 0 and both buffer enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Correction request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_sector | input | 3 | Sector slot of the request |
| sector_done | input | 8 | Per-slot decoder done levels |
| err_cnt_word | input | 32 | Packed 4-bit error counts, slot n at bit 4n |
| err_loc_bank | input | 224 | Seven location words, two 13-bit locations each |
| mem_rd_en | output | 1 | Buffer read request, data one cycle later |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_addr | output | 10 | Buffer byte address |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Byte read from the buffer |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_count | output | 4 | Number of reported errors |
| res_uncorr | output | 1 | Sector uncorrectable |

## Verification
On every cycle, the assertions check the shape of the buffer traffic. Each write must directly follow a read of the same address. Read and write never happen together, no enabled address lies beyond the free-data area, and the result stays stable under back-pressure. An uncorrectable result must never carry a count. Only the bench scenarios can show the rest: that the right slot's field is used, that the half-word packing and the region boundaries at 4096 and 4160 land on the right byte and bit, and that repeated locations cancel. These are checked against a reference copy of the buffer with random injected errors.

// File: rtl/eccfix_pkg.sv
package eccfix_pkg;
  localparam int LOC_W     = 13;
  localparam int CNT_W     = 4;
  localparam int ODD_SHIFT = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STEP,
    ST_MOD,
    ST_RESP
  } fix_state_e;

  typedef enum logic [1:0] {
    REG_DATA,
    REG_FREE,
    REG_PARITY
  } loc_region_e;
endpackage

// File: rtl/eccfix_count_sel.sv
module eccfix_count_sel
  import eccfix_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int SEL_W = 3
) (
  input  logic [NSECT*CNT_W-1:0] cnt_word,
  input  logic [SEL_W-1:0]       sel,
  output logic [CNT_W-1:0]       cnt
);
  logic [CNT_W-1:0] fields [NSECT];

  for (genvar g = 0; g < NSECT; g++) begin : g_field
    assign fields[g] = cnt_word[g*CNT_W +: CNT_W];
  end

  assign cnt = fields[sel];
endmodule

// File: rtl/eccfix_loc_decode.sv
module eccfix_loc_decode
  import eccfix_pkg::*;
#(
  parameter int LOC_WORDS  = 7,
  parameter int SECT_BYTES = 512,
  parameter int FREE_BYTES = 8,
  parameter int AW         = 10
) (
  input  logic [LOC_WORDS*32-1:0] bank,
  input  logic [CNT_W-1:0]        idx,
  output logic [AW-1:0]           byte_addr,
  output logic [2:0]              bit_sel,
  output loc_region_e             region
);
  localparam int NLOC = 2 * LOC_WORDS;
  localparam logic [LOC_W-1:0] DATA_END = LOC_W'(SECT_BYTES * 8);
  localparam logic [LOC_W-1:0] FREE_END = LOC_W'((SECT_BYTES + FREE_BYTES) * 8);

  logic [LOC_W-1:0] locs [NLOC];
  logic [LOC_W-1:0] loc;

  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    assign locs[g] = bank[(g/2)*32 + (g%2)*ODD_SHIFT +: LOC_W];
  end

  always_comb begin
    loc = '0;
    for (int i = 0; i < NLOC; i++) begin
      if (idx == CNT_W'(i)) loc = locs[i];
    end
  end

  assign byte_addr = AW'(loc >> 3);
  assign bit_sel   = loc[2:0];

  always_comb begin
    if (loc < DATA_END)      region = REG_DATA;
    else if (loc < FREE_END) region = REG_FREE;
    else                     region = REG_PARITY;
  end
endmodule

// File: rtl/eccfix_seq.sv
module eccfix_seq
  import eccfix_pkg::*;
#(
  parameter int NSECT     = 8,
  parameter int SEL_W     = 3,
  parameter int AW        = 10,
  parameter int BUF_BYTES = 520
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_sector,
  input  logic [NSECT-1:0] sector_done,
  output logic [SEL_W-1:0] sel_sector,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             load,
  output logic [CNT_W-1:0] idx,
  input  logic [AW-1:0]    dec_addr,
  input  logic [2:0]       dec_bit,
  input  loc_region_e      dec_region,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] res_count,
  output logic             res_uncorr
);
  localparam logic [AW-1:0] BUF_END = AW'(BUF_BYTES);

  fix_state_e       state_q;
  logic [SEL_W-1:0] sect_q;
  logic [CNT_W-1:0] cnt_q, idx_q, fixed_q;
  logic             uncorr_q;
  logic [AW-1:0]    addr_q;
  logic [2:0]       bit_q;
  logic             step_go;

  assign req_ready  = (state_q == ST_IDLE);
  assign sel_sector = sect_q;
  assign load       = (state_q == ST_WAIT) && sector_done[sect_q];
  assign idx        = idx_q;
  assign step_go    = (state_q == ST_STEP) && !uncorr_q && (idx_q != cnt_q);
  assign mem_rd_en  = step_go && (dec_region != REG_PARITY);
  assign mem_wr_en  = (state_q == ST_MOD);
  assign mem_addr   = mem_wr_en ? addr_q : dec_addr;
  assign mem_wdata  = mem_rdata ^ (8'd1 << bit_q);
  assign res_valid  = (state_q == ST_RESP);
  assign res_count  = fixed_q;
  assign res_uncorr = uncorr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sect_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      fixed_q  <= '0;
      uncorr_q <= 1'b0;
      addr_q   <= '0;
      bit_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          sect_q  <= req_sector;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (load) begin
          cnt_q    <= cnt_in;
          uncorr_q <= (cnt_in == '1);
          idx_q    <= '0;
          fixed_q  <= '0;
          state_q  <= ST_STEP;
        end
        ST_STEP: begin
          if (!step_go) begin
            state_q <= ST_RESP;
          end else if (dec_region == REG_PARITY) begin
            fixed_q <= fixed_q + 1'b1;
            idx_q   <= idx_q + 1'b1;
          end else begin
            addr_q  <= dec_addr;
            bit_q   <= dec_bit;
            state_q <= ST_MOD;
          end
        end
        ST_MOD: begin
          fixed_q <= fixed_q + 1'b1;
          idx_q   <= idx_q + 1'b1;
          state_q <= ST_STEP;
        end
        ST_RESP: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |-> $past(mem_rd_en)); // R10
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |-> mem_addr == $past(mem_addr)); // R10
  AST_NO_RD_WR_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd_en && mem_wr_en)); // R10
  AST_ADDR_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd_en || mem_wr_en) |-> mem_addr < BUF_END); // R7
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_ready) |=> (res_valid && $stable(res_count) && $stable(res_uncorr))); // R11
  AST_UNCORR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_uncorr) |-> res_count == '0); // R3
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !(res_valid || mem_rd_en || mem_wr_en)); // R11
endmodule

// File: rtl/ecc_bitfix_top.sv
module ecc_bitfix_top
  import eccfix_pkg::*;
#(
  parameter int NSECT      = 8,
  parameter int MAX_ERR    = 14,
  parameter int SECT_BYTES = 512,
  parameter int FREE_BYTES = 8,
  localparam int SEL_W     = $clog2(NSECT),
  localparam int LOC_WORDS = (MAX_ERR + 1) / 2,
  localparam int BUF_BYTES = SECT_BYTES + FREE_BYTES,
  localparam int AW        = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [SEL_W-1:0]       req_sector,
  input  logic [NSECT-1:0]       sector_done,
  input  logic [NSECT*CNT_W-1:0] err_cnt_word,
  input  logic [LOC_WORDS*32-1:0] err_loc_bank,
  output logic                   mem_rd_en,
  output logic                   mem_wr_en,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [CNT_W-1:0]       res_count,
  output logic                   res_uncorr
);
  logic [SEL_W-1:0]       sel_sector;
  logic [CNT_W-1:0]       cnt_sel, idx;
  logic                   load;
  logic [LOC_WORDS*32-1:0] bank_q;
  logic [AW-1:0]          dec_addr;
  logic [2:0]             dec_bit;
  loc_region_e            dec_region;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= err_loc_bank;
  end

  eccfix_count_sel #(.NSECT(NSECT), .SEL_W(SEL_W)) u_cnt (
    .cnt_word (err_cnt_word),
    .sel      (sel_sector),
    .cnt      (cnt_sel)
  );

  eccfix_loc_decode #(
    .LOC_WORDS(LOC_WORDS), .SECT_BYTES(SECT_BYTES),
    .FREE_BYTES(FREE_BYTES), .AW(AW)
  ) u_dec (
    .bank      (bank_q),
    .idx       (idx),
    .byte_addr (dec_addr),
    .bit_sel   (dec_bit),
    .region    (dec_region)
  );

  eccfix_seq #(
    .NSECT(NSECT), .SEL_W(SEL_W), .AW(AW), .BUF_BYTES(BUF_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_sector (req_sector),
    .sector_done(sector_done),
    .sel_sector (sel_sector),
    .cnt_in     (cnt_sel),
    .load       (load),
    .idx        (idx),
    .dec_addr   (dec_addr),
    .dec_bit    (dec_bit),
    .dec_region (dec_region),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_count  (res_count),
    .res_uncorr (res_uncorr)
  );
endmodule

// File: tb/ecc_bitfix_top_tb_top.sv
module ecc_bitfix_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUFN = 520;
  localparam int NCASE = 10;
  // {slot[2:0], count[3:0]}
  localparam logic [6:0] CASES [NCASE] = '{
    {3'd0, 4'd1}, {3'd1, 4'd3}, {3'd2, 4'd14}, {3'd3, 4'd7}, {3'd4, 4'd2},
    {3'd5, 4'd9}, {3'd6, 4'd5}, {3'd7, 4'd14}, {3'd0, 4'd4}, {3'd7, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, res_ready = 1'b0;
  logic [2:0] req_sector = '0;
  logic [7:0] sector_done = '0;
  logic [31:0] err_cnt_word = '0;
  logic [223:0] err_loc_bank = '0;
  logic req_ready, mem_rd_en, mem_wr_en, res_valid, res_uncorr;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [3:0] res_count;

  logic [7:0] mem [BUFN];
  logic [7:0] expbuf [BUFN];
  int job_locs [14];
  int acc_cnt = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_bitfix_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sector(req_sector), .sector_done(sector_done), .err_cnt_word(err_cnt_word),
    .err_loc_bank(err_loc_bank), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_count(res_count),
    .res_uncorr(res_uncorr)
  );

  always @(posedge clk) begin
    if (mem_wr_en && mem_addr < BUFN) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= (mem_addr < BUFN) ? mem[mem_addr] : 8'hxx;
    if (mem_rd_en || mem_wr_en) acc_cnt <= acc_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Run one job: slot, count, locations in job_locs; done raised after dly cycles,
  // result held unacknowledged for hold cycles. exp_acc < 0 skips the access check.
  task automatic run_job(input int slot, input int cnt, input int dly, input int hold,
                         input int exp_acc, input string req);
    int a0, mism, nflip;
    logic [3:0] c0;
    for (int n = 0; n < 8; n++) err_cnt_word[4*n +: 4] = 4'(n == slot ? cnt : (15 - n + slot) % 16);
    for (int k = 0; k < 7; k++) err_loc_bank[32*k +: 32] = $urandom;
    for (int i = 0; i < 14; i++) err_loc_bank[(i/2)*32 + (i%2)*16 +: 13] = 13'(job_locs[i]);
    nflip = 0;
    if (cnt != 0 && cnt != 15)
      for (int i = 0; i < cnt; i++)
        if (job_locs[i] < 4160) begin
          expbuf[job_locs[i] >> 3] ^= 8'(1 << (job_locs[i] & 7));
          nflip++;
        end
    req_sector = 3'(slot);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    a0 = acc_cnt;
    repeat (dly) @(negedge clk);
    check(acc_cnt == a0, "R9", "accesses before done", acc_cnt - a0, 0);
    sector_done[slot] = 1'b1;
    for (int t = 0; t < 200 && !res_valid; t++) @(negedge clk);
    check(res_valid == 1'b1, "R11", "res_valid", res_valid, 1);
    c0 = res_count;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(res_valid && res_count == c0, "R11", "result held", res_count, c0);
    end
    check(res_uncorr == (cnt == 15), req, "res_uncorr", res_uncorr, cnt == 15);
    check(res_count == (cnt == 15 ? 0 : cnt), req, "res_count", res_count, cnt == 15 ? 0 : cnt);
    if (exp_acc >= 0) check(acc_cnt - a0 == exp_acc, req, "buffer accesses", acc_cnt - a0, exp_acc);
    else check(acc_cnt - a0 == 2 * nflip, "R10", "buffer accesses", acc_cnt - a0, 2 * nflip);
    mism = 0;
    for (int b = 0; b < BUFN; b++) if (mem[b] !== expbuf[b]) mism++;
    check(mism == 0, req, "buffer mismatches", mism, 0);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    sector_done = '0;
    check(!res_valid && req_ready, "R11", "release after ack", res_valid, 0);
  endtask

  initial begin
    for (int b = 0; b < BUFN; b++) begin
      mem[b] = 8'(b * 7 + 3);
      expbuf[b] = 8'(b * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R12", "req_ready in reset", req_ready, 1);
    check(!res_valid && !mem_rd_en && !mem_wr_en, "R12", "outputs in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !res_valid, "R12", "idle after reset", req_ready, 1);

    // Table of random-injection cases: R1 (slot select), R4, R5, R6, R8
    for (int c = 0; c < NCASE; c++) begin
      for (int i = 0; i < 14; i++) job_locs[i] = $urandom_range(0, 4299);
      run_job(int'(CASES[c][6:4]), int'(CASES[c][3:0]), c % 3, c % 2, -1, "R1 R8");
    end

    // R2: zero count
    for (int i = 0; i < 14; i++) job_locs[i] = i * 8;
    run_job(5, 0, 1, 0, 0, "R2");
    // R3: uncorrectable
    run_job(2, 15, 1, 0, 0, "R3");
    // R5 R6 R7: boundary locations
    job_locs[0] = 4095; job_locs[1] = 4096; job_locs[2] = 4159; job_locs[3] = 4160;
    run_job(3, 4, 0, 0, 6, "R6");
    // R7: parity-only locations still counted
    job_locs[0] = 4160; job_locs[1] = 4200; job_locs[2] = 8191;
    run_job(6, 3, 0, 0, 0, "R7");
    // R10 R4: same bit reported twice (even and odd half of one word) cancels
    job_locs[0] = 100; job_locs[1] = 100; job_locs[2] = 0;
    run_job(1, 3, 0, 0, 6, "R10");
    // R9 R11: late done and long back-pressure
    job_locs[0] = 17; job_locs[1] = 4100;
    run_job(4, 2, 12, 5, 4, "R5");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule